// File: doc/BRIEF.md
# Landing-Pad Expected-State Trap Tracker

This block holds the one-bit "landing pad expected" state of a hart that enforces forward-edge control-flow integrity, together with two saved copies of that state: one for traps taken into supervisor mode and one for traps taken into machine mode. From the current privilege, the virtualization flag and the per-level configuration enable bits, it works out whether landing-pad enforcement is active. That result decides whether a trap saves the state and whether a trap return brings it back.

The pipeline reports a trap, a trap return or a direct write of the state through strobes. At most one of these takes effect on a given clock edge: a trap wins over a return, and a return wins over a direct write. All three state bits change together on that edge. A parameter says whether the hart implements supervisor mode, and this changes where the user-level enable comes from.

Top module: `lp_track`

## Requirements
- R1: After reset, `lp_expected`, `spelp` and `mpelp` are 0. The value 0 means no landing pad is expected and 1 means one is expected.
- R2: `lpe_active` is 0 whenever `ext_present` is 0.
- R3: With `ext_present` high and `cur_priv` = 0 (user), `lpe_active` follows `senv_lpe` when `SUPV_PRESENT` = 1 and follows `menv_lpe` when `SUPV_PRESENT` = 0.
- R4: With `ext_present` high and `cur_priv` = 1 (supervisor), `lpe_active` follows `henv_lpe` when `virt_on` = 1 and follows `menv_lpe` when `virt_on` = 0.
- R5: With `ext_present` high, `lpe_active` follows `msec_mlpe` for `cur_priv` = 3 (machine) and is 0 for the reserved value `cur_priv` = 2.
- R6: On a trap, if enforcement is active for the privilege before the trap, `lp_expected` is copied into `mpelp` when `trap_to_m` = 1 and into `spelp` when `trap_to_m` = 0. The bit that is not the target keeps its value, and so does the target bit when enforcement is inactive.
- R7: On a trap, `lp_expected` becomes 0 on the next edge if `ext_present` = 1, and keeps its value otherwise.
- R8: On a return (`ret_is_m` = 0 for a supervisor return, 1 for a machine return), enforcement is evaluated for `ret_priv`/`ret_virt`. `lp_expected` takes the matching saved bit if enforcement is active, and becomes 0 if not.
- R9: On a return, the matching saved bit is cleared to 0 whatever the enable is. The other saved bit keeps its value.
- R10: A trap and a return in the same cycle act as the trap alone.
- R11: `elp_load` with no trap or return writes `elp_load_val` into `lp_expected` and leaves both saved bits unchanged.
- R12: `spelp_vis` is 1 exactly when `ext_present` and `henv_lpe` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_present | input | 1 | Landing-pad extension implemented |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_on | input | 1 | Current virtualization mode |
| senv_lpe | input | 1 | Supervisor environment-config enable |
| menv_lpe | input | 1 | Machine environment-config enable |
| henv_lpe | input | 1 | Hypervisor environment-config enable |
| msec_mlpe | input | 1 | Machine security-config enable for M mode |
| trap_req | input | 1 | Trap delivered this cycle |
| trap_to_m | input | 1 | Trap handled in M (1) or S (0) |
| ret_req | input | 1 | Trap return this cycle |
| ret_is_m | input | 1 | Machine return (1) or supervisor return (0) |
| ret_priv | input | 2 | Privilege the return switches to |
| ret_virt | input | 1 | Virtualization mode after the return |
| elp_load | input | 1 | Direct write of the expected state |
| elp_load_val | input | 1 | Value for the direct write |
| lp_expected | output | 1 | Expected-landing-pad state |
| spelp | output | 1 | Saved state for S-mode traps |
| mpelp | output | 1 | Saved state for M-mode traps |
| lpe_active | output | 1 | Enforcement active at `cur_priv` |
| spelp_vis | output | 1 | Saved S bit visible in swapped status view |

## Verification
The bench builds two copies of the block: one with `SUPV_PRESENT` = 1 and one with `SUPV_PRESENT` = 0. Running them side by side makes both sources of the user-level enable reachable under the same stimulus. The bench covers all 256 combinations of extension flag, privilege, virtualization and the four enable bits for the enable output. It then drives several thousand pseudo-random cycles of traps, returns, collisions and writes against a reference model in the bench, so that every save, restore and clear path is taken with both enable values.

// File: rtl/lp_track_pkg.sv
package lp_track_pkg;
    localparam int PRIV_W = 2;

    localparam logic [PRIV_W-1:0] PRIV_U = 2'd0;
    localparam logic [PRIV_W-1:0] PRIV_S = 2'd1;
    localparam logic [PRIV_W-1:0] PRIV_M = 2'd3;

    localparam logic NO_LP  = 1'b0;
    localparam logic LP_EXP = 1'b1;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_TRAP_S,
        EV_TRAP_M,
        EV_RET_S,
        EV_RET_M,
        EV_LOAD
    } lp_event_e;

    typedef struct packed {
        logic elp;
        logic spelp;
        logic mpelp;
    } lp_state_t;
endpackage

// File: rtl/lp_enable_sel.sv
module lp_enable_sel
    import lp_track_pkg::*;
#(
    parameter bit SUPV_PRESENT = 1'b1
) (
    input  logic              ext_present,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              senv_lpe,
    input  logic              menv_lpe,
    input  logic              henv_lpe,
    input  logic              msec_mlpe,
    output logic              enable
);
    logic user_en;
    logic raw_en;

    generate
        if (SUPV_PRESENT) begin : g_user_supv
            assign user_en = senv_lpe;
        end else begin : g_user_mach
            assign user_en = menv_lpe;
        end
    endgenerate

    always_comb begin
        unique case (priv)
            PRIV_U:  raw_en = user_en;
            PRIV_S:  raw_en = virt ? henv_lpe : menv_lpe;
            PRIV_M:  raw_en = msec_mlpe;
            default: raw_en = 1'b0;
        endcase
    end

    assign enable = ext_present & raw_en;
endmodule

// File: rtl/lp_event_dec.sv
module lp_event_dec
    import lp_track_pkg::*;
(
    input  logic      trap_req,
    input  logic      trap_to_m,
    input  logic      ret_req,
    input  logic      ret_is_m,
    input  logic      elp_load,
    output lp_event_e evt
);
    always_comb begin
        if (trap_req) begin
            evt = trap_to_m ? EV_TRAP_M : EV_TRAP_S;
        end else if (ret_req) begin
            evt = ret_is_m ? EV_RET_M : EV_RET_S;
        end else if (elp_load) begin
            evt = EV_LOAD;
        end else begin
            evt = EV_NONE;
        end
    end
endmodule

// File: rtl/lp_track.sv
module lp_track
    import lp_track_pkg::*;
#(
    parameter bit SUPV_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_present,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              virt_on,
    input  logic              senv_lpe,
    input  logic              menv_lpe,
    input  logic              henv_lpe,
    input  logic              msec_mlpe,
    input  logic              trap_req,
    input  logic              trap_to_m,
    input  logic              ret_req,
    input  logic              ret_is_m,
    input  logic [PRIV_W-1:0] ret_priv,
    input  logic              ret_virt,
    input  logic              elp_load,
    input  logic              elp_load_val,
    output logic              lp_expected,
    output logic              spelp,
    output logic              mpelp,
    output logic              lpe_active,
    output logic              spelp_vis
);
    lp_state_t st_d, st_q;
    lp_event_e evt;
    logic      en_cur;
    logic      en_ret;

    lp_enable_sel #(.SUPV_PRESENT(SUPV_PRESENT)) i_en_cur (
        .ext_present (ext_present),
        .priv        (cur_priv),
        .virt        (virt_on),
        .senv_lpe    (senv_lpe),
        .menv_lpe    (menv_lpe),
        .henv_lpe    (henv_lpe),
        .msec_mlpe   (msec_mlpe),
        .enable      (en_cur)
    );

    lp_enable_sel #(.SUPV_PRESENT(SUPV_PRESENT)) i_en_ret (
        .ext_present (ext_present),
        .priv        (ret_priv),
        .virt        (ret_virt),
        .senv_lpe    (senv_lpe),
        .menv_lpe    (menv_lpe),
        .henv_lpe    (henv_lpe),
        .msec_mlpe   (msec_mlpe),
        .enable      (en_ret)
    );

    lp_event_dec i_dec (
        .trap_req  (trap_req),
        .trap_to_m (trap_to_m),
        .ret_req   (ret_req),
        .ret_is_m  (ret_is_m),
        .elp_load  (elp_load),
        .evt       (evt)
    );

    always_comb begin
        st_d = st_q;
        unique case (evt)
            EV_TRAP_S: begin
                if (en_cur) st_d.spelp = st_q.elp;
                if (ext_present) st_d.elp = NO_LP;
            end
            EV_TRAP_M: begin
                if (en_cur) st_d.mpelp = st_q.elp;
                if (ext_present) st_d.elp = NO_LP;
            end
            EV_RET_S: begin
                st_d.elp   = en_ret ? st_q.spelp : NO_LP;
                st_d.spelp = NO_LP;
            end
            EV_RET_M: begin
                st_d.elp   = en_ret ? st_q.mpelp : NO_LP;
                st_d.mpelp = NO_LP;
            end
            EV_LOAD: begin
                st_d.elp = elp_load_val;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{elp: NO_LP, spelp: NO_LP, mpelp: NO_LP};
        end else begin
            st_q <= st_d;
        end
    end

    assign lp_expected = st_q.elp;
    assign spelp       = st_q.spelp;
    assign mpelp       = st_q.mpelp;
    assign lpe_active  = en_cur;
    assign spelp_vis   = ext_present & henv_lpe;
endmodule

// File: rtl/lp_track_chk.sv
module lp_track_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_present,
    input logic trap_req,
    input logic trap_to_m,
    input logic ret_req,
    input logic ret_is_m,
    input logic lp_expected,
    input logic spelp,
    input logic mpelp,
    input logic lpe_active
);
    // R2
    ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_present |-> !lpe_active);

    // R7
    trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && ext_present) |=> !lp_expected);

    // R6
    trap_s_keep_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_to_m) |=> $stable(mpelp));

    // R6
    trap_m_keep_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_to_m) |=> $stable(spelp));

    // R9
    sret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && !ret_is_m) |=> !spelp);

    // R9
    mret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req && ret_is_m) |=> !mpelp);

    // R10
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_to_m && ret_req && ret_is_m) |=> $stable(mpelp));
endmodule

bind lp_track lp_track_chk i_lp_track_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_present (ext_present),
    .trap_req    (trap_req),
    .trap_to_m   (trap_to_m),
    .ret_req     (ret_req),
    .ret_is_m    (ret_is_m),
    .lp_expected (lp_expected),
    .spelp       (spelp),
    .mpelp       (mpelp),
    .lpe_active  (lpe_active)
);

// File: tb/test_lp_track.sv
`timescale 1ns/1ps
module test_lp_track;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_present = 1'b0;
    logic [1:0] cur_priv = 2'd0;
    logic virt_on = 1'b0;
    logic senv_lpe = 1'b0, menv_lpe = 1'b0, henv_lpe = 1'b0, msec_mlpe = 1'b0;
    logic trap_req = 1'b0, trap_to_m = 1'b0;
    logic ret_req = 1'b0, ret_is_m = 1'b0;
    logic [1:0] ret_priv = 2'd0;
    logic ret_virt = 1'b0;
    logic elp_load = 1'b0, elp_load_val = 1'b0;

    logic [1:0] o_elp, o_sp, o_mp, o_act, o_vis;

    int n_chk = 0;
    int n_bad = 0;
    logic m_elp [2];
    logic m_sp  [2];
    logic m_mp  [2];

    always #4 clk = ~clk;

    lp_track #(.SUPV_PRESENT(1'b1)) i_lp_track (
        .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .cur_priv(cur_priv),
        .virt_on(virt_on), .senv_lpe(senv_lpe), .menv_lpe(menv_lpe),
        .henv_lpe(henv_lpe), .msec_mlpe(msec_mlpe), .trap_req(trap_req),
        .trap_to_m(trap_to_m), .ret_req(ret_req), .ret_is_m(ret_is_m),
        .ret_priv(ret_priv), .ret_virt(ret_virt), .elp_load(elp_load),
        .elp_load_val(elp_load_val), .lp_expected(o_elp[1]), .spelp(o_sp[1]),
        .mpelp(o_mp[1]), .lpe_active(o_act[1]), .spelp_vis(o_vis[1])
    );

    lp_track #(.SUPV_PRESENT(1'b0)) i_lp_track_nos (
        .clk(clk), .rst_n(rst_n), .ext_present(ext_present), .cur_priv(cur_priv),
        .virt_on(virt_on), .senv_lpe(senv_lpe), .menv_lpe(menv_lpe),
        .henv_lpe(henv_lpe), .msec_mlpe(msec_mlpe), .trap_req(trap_req),
        .trap_to_m(trap_to_m), .ret_req(ret_req), .ret_is_m(ret_is_m),
        .ret_priv(ret_priv), .ret_virt(ret_virt), .elp_load(elp_load),
        .elp_load_val(elp_load_val), .lp_expected(o_elp[0]), .spelp(o_sp[0]),
        .mpelp(o_mp[0]), .lpe_active(o_act[0]), .spelp_vis(o_vis[0])
    );

    // Expected enable taken from R2..R5
    function automatic logic ref_en(input logic supv, input logic [1:0] p, input logic v);
        logic r;
        if (!ext_present) return 1'b0;
        case (p)
            2'd0: r = supv ? senv_lpe : menv_lpe;
            2'd1: r = v ? henv_lpe : menv_lpe;
            2'd3: r = msec_mlpe;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string en_tag(input logic [1:0] p);
        if (!ext_present) return "R2";
        case (p)
            2'd0: return "R3";
            2'd1: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rng;
        logic        e_elp [2];
        logic        e_sp  [2];
        logic        e_mp  [2];
        logic        ec, er;
        string       tag;

        repeat (3) @(posedge clk);
        #2;
        for (int k = 0; k < 2; k++) begin
            chk("R1 elp", o_elp[k], 1'b0);
            chk("R1 spelp", o_sp[k], 1'b0);
            chk("R1 mpelp", o_mp[k], 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++) begin
            m_elp[k] = 1'b0; m_sp[k] = 1'b0; m_mp[k] = 1'b0;
        end

        // Exhaustive sweep of the enable and visibility outputs
        for (int i = 0; i < 256; i++) begin
            ext_present = i[0];
            cur_priv    = i[2:1];
            virt_on     = i[3];
            senv_lpe    = i[4];
            menv_lpe    = i[5];
            henv_lpe    = i[6];
            msec_mlpe   = i[7];
            #1;
            for (int k = 0; k < 2; k++) begin
                chk(en_tag(cur_priv), o_act[k], ref_en(k[0], cur_priv, virt_on));
                chk("R12", o_vis[k], ext_present & henv_lpe);
            end
        end

        // Pseudo-random sequence against the reference model
        rng = 32'h1ace_b00c;
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            ext_present  = rng[0] | rng[1] | rng[2];
            cur_priv     = rng[4:3];
            virt_on      = rng[5];
            senv_lpe     = rng[6] | rng[20];
            menv_lpe     = rng[7] | rng[21];
            henv_lpe     = rng[8] | rng[22];
            msec_mlpe    = rng[9] | rng[23];
            trap_req     = rng[10] & rng[11];
            trap_to_m    = rng[12];
            ret_req      = rng[13] & rng[14];
            ret_is_m     = rng[15];
            ret_priv     = rng[17:16];
            ret_virt     = rng[18];
            elp_load     = rng[19] | rng[24];
            elp_load_val = rng[25] | rng[26];
            #1;
            for (int k = 0; k < 2; k++) begin
                ec = ref_en(k[0], cur_priv, virt_on);
                er = ref_en(k[0], ret_priv, ret_virt);
                e_elp[k] = m_elp[k]; e_sp[k] = m_sp[k]; e_mp[k] = m_mp[k];
                if (trap_req) begin
                    tag = ret_req ? "R10 R6 R7" : "R6 R7";
                    if (ec && trap_to_m)  e_mp[k] = m_elp[k];
                    if (ec && !trap_to_m) e_sp[k] = m_elp[k];
                    if (ext_present) e_elp[k] = 1'b0;
                end else if (ret_req) begin
                    tag = "R8 R9";
                    if (ret_is_m) begin
                        e_elp[k] = er ? m_mp[k] : 1'b0;
                        e_mp[k]  = 1'b0;
                    end else begin
                        e_elp[k] = er ? m_sp[k] : 1'b0;
                        e_sp[k]  = 1'b0;
                    end
                end else if (elp_load) begin
                    tag = "R11";
                    e_elp[k] = elp_load_val;
                end else begin
                    tag = "idle";
                end
                m_elp[k] = e_elp[k]; m_sp[k] = e_sp[k]; m_mp[k] = e_mp[k];
            end
            @(posedge clk);
            #1;
            for (int k = 0; k < 2; k++) begin
                chk({tag, " elp"},   o_elp[k], m_elp[k]);
                chk({tag, " spelp"}, o_sp[k],  m_sp[k]);
                chk({tag, " mpelp"}, o_mp[k],  m_mp[k]);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule